// File: doc/BRIEF.md
# Two-Operand Instruction Execution Sequencer

This block carries out one 16-bit instruction word of a small word-oriented processor whose general registers live in memory. When `start` is pulsed while the block is idle, it counts the leading zero bits of the word to find the instruction class. Only the class with two general operands is executed. Every other class, and every two-operand word that uses the symbolic/indexed or auto-increment addressing modes, ends with a one-clock `unsupported` pulse and no memory traffic.

An executed instruction runs as a chain of machine cycles. The block fetches a pointer first for each register-indirect operand. It then reads the source operand, reads the destination operand, runs one ALU cycle against an external combinational ALU, and writes the result back to the destination. Each machine cycle takes four internal phases: address compute, address drive, strobe and capture. The strobe phase holds a word-wide request until the memory acknowledges it.

A build option removes the destination read for the word move. Every other operation, the byte move included, keeps read-before-write.

Top module: `dos_sequencer`

## Requirements
- R1: The block selects the instruction class from the count of leading zero bits. A word with zero or one leading zero (bits 15..14 not both 0) is executed. Any other word gives a one-clock `unsupported` pulse in the clock after `start` is sampled, issues no memory request and never raises `done`.
- R2: The 2-bit addressing modes are 00 register and 01 register-indirect. A two-operand word with mode 10 or 11 in either the source field (bits 5..4) or the destination field (bits 11..10) is rejected exactly as in R1.
- R3: Bits 15..13 reach `alu_op` unchanged, and bit 12 reaches `alu_byte`. The destination register number sits in bits 9..6, and the source register number in bits 3..0.
- R4: A register-mode operand is accessed at the address `wp + 2*register`.
- R5: A register-indirect operand first reads `wp + 2*register`, then uses the word read as the operand address. The pointer read comes just before that operand's own access.
- R6: Accesses occur in this order: source pointer (if any), source read, destination pointer (if any), destination read, then a single write to the destination address.
- R7: When `FAST_MOVE` is 1, a word move (operation 110, byte flag 0) skips the destination read. A byte move and all other operations still perform it.
- R8: The written word equals `alu_res`, computed with `alu_src` set to the source word and `alu_dst` set to the destination word.
- R9: With a memory that acknowledges one clock after the request rises, a memory machine cycle takes 5 clocks and the ALU cycle takes 4 clocks. `done` is therefore visible 5×accesses+4 clocks after the clock that samples `start`.
- R10: While `mem_req` is high and `mem_ack` is low, the request, address and write enable hold steady. Each clock of acknowledge delay adds one clock of latency.
- R11: `done` is a one-clock pulse that follows the final write, after which the block is idle again (`busy` low).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin an instruction; sampled only when idle |
| instr | input | 16 | Instruction word |
| wp | input | AW | Register-file base address, held during an instruction |
| busy | output | 1 | Instruction in progress |
| done | output | 1 | One-clock pulse after the destination write |
| unsupported | output | 1 | One-clock pulse for a rejected class or mode |
| mem_req | output | 1 | Memory request, held until acknowledged |
| mem_we | output | 1 | Request is a write |
| mem_addr | output | AW | Word address of the request |
| mem_wdata | output | DW | Write data |
| mem_rdata | input | DW | Read data, valid with `mem_ack` |
| mem_ack | input | 1 | Memory acknowledge |
| alu_op | output | 3 | Operation field to the ALU |
| alu_byte | output | 1 | Byte flag to the ALU |
| alu_src | output | DW | Source operand to the ALU |
| alu_dst | output | DW | Destination operand to the ALU |
| alu_res | input | DW | Combinational ALU result |

## Verification
A rejected word is due in the first clock after `start` is sampled, so the bench looks for `unsupported` at the first falling edge after that clock. For an executed word, the bench adds up the expected latency before issuing `start`. It counts 5 clocks for each access plus the delay its memory model is set to insert, and 4 clocks for the ALU cycle. It then counts falling edges until `done` and compares that count with the expected value. The access log, the result word and `alu_op`/`alu_byte` are read at the falling edge where `done` is seen. One falling edge later, the bench confirms that `done` has dropped.

// File: rtl/dos_pkg.sv
package dos_pkg;

   localparam int DOS_IW = 16;
   localparam int DOS_RW = 4;

   localparam logic [1:0] AM_REG = 2'b00;
   localparam logic [1:0] AM_IND = 2'b01;
   localparam logic [2:0] OP_MOVE = 3'b110;

   typedef struct packed {
      logic [2:0]        op;
      logic              bsel;
      logic [1:0]        dmode;
      logic [DOS_RW-1:0] dreg;
      logic [1:0]        smode;
      logic [DOS_RW-1:0] sreg;
   } dos_fields_t;

   typedef enum logic [2:0] {
      CLS_TWO, CLS_REGSRC, CLS_JUMP, CLS_SHIFT, CLS_SINGLE, CLS_IMMED, CLS_OTHER
   } dos_class_e;

   typedef enum logic [2:0] {
      ST_IDLE, ST_SPTR, ST_SRD, ST_DPTR, ST_DRD, ST_ALU, ST_WR
   } dos_state_e;

   typedef enum logic [1:0] {
      PH_ADDR, PH_DRIVE, PH_STROBE, PH_CAPT
   } dos_phase_e;

endpackage

// File: rtl/dos_lzc.sv
module dos_lzc #(
   parameter int W  = 16,
   parameter int CW = $clog2(W + 1)
) (
   input  logic [W-1:0]  word,
   output logic [CW-1:0] zeros
);
   logic hit;

   always_comb begin
      zeros = '0;
      hit   = 1'b0;
      for (int i = W - 1; i >= 0; i--) begin
         if (!hit) begin
            if (word[i]) hit = 1'b1;
            else         zeros = zeros + CW'(1);
         end
      end
   end
endmodule

// File: rtl/dos_decode.sv
module dos_decode
   import dos_pkg::*;
#(
   parameter bit FAST_MOVE = 1'b1
) (
   input  logic [DOS_IW-1:0] instr,
   output dos_fields_t       fld,
   output logic              exec_ok,
   output logic              skip_dst
);
   localparam int ZW = $clog2(DOS_IW + 1);

   logic [ZW-1:0] zeros;
   dos_class_e    cls;

   dos_lzc #(.W(DOS_IW), .CW(ZW)) u_lzc (.word(instr), .zeros(zeros));

   assign fld = dos_fields_t'(instr);

   always_comb begin
      case (zeros)
         ZW'(0), ZW'(1): cls = CLS_TWO;
         ZW'(2):         cls = CLS_REGSRC;
         ZW'(3):         cls = CLS_JUMP;
         ZW'(4):         cls = CLS_SHIFT;
         ZW'(5):         cls = CLS_SINGLE;
         ZW'(6):         cls = CLS_IMMED;
         default:        cls = CLS_OTHER;
      endcase
   end

   assign exec_ok = (cls == CLS_TWO) && !fld.smode[1] && !fld.dmode[1];

   generate
      if (FAST_MOVE) begin : g_fast
         assign skip_dst = (fld.op == OP_MOVE) && !fld.bsel;
      end else begin : g_full
         assign skip_dst = 1'b0;
      end
   endgenerate
endmodule

// File: rtl/dos_sequencer.sv
module dos_sequencer
   import dos_pkg::*;
#(
   parameter int AW        = 16,
   parameter int DW        = 16,
   parameter bit FAST_MOVE = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic [DOS_IW-1:0] instr,
   input  logic [AW-1:0]     wp,
   output logic              busy,
   output logic              done,
   output logic              unsupported,
   output logic              mem_req,
   output logic              mem_we,
   output logic [AW-1:0]     mem_addr,
   output logic [DW-1:0]     mem_wdata,
   input  logic [DW-1:0]     mem_rdata,
   input  logic              mem_ack,
   output logic [2:0]        alu_op,
   output logic              alu_byte,
   output logic [DW-1:0]     alu_src,
   output logic [DW-1:0]     alu_dst,
   input  logic [DW-1:0]     alu_res
);
   generate
      if (DW != DOS_IW) begin : g_dw_bad
         $error("dos_sequencer: DW must equal the instruction width");
      end
      if (AW > DW || AW < DOS_RW + 2) begin : g_aw_bad
         $error("dos_sequencer: AW out of range");
      end
   endgenerate

   dos_fields_t fld_d, fld_q;
   logic        exec_ok, skip_d, skip_q;
   dos_state_e  state;
   dos_phase_e  ph;
   logic [AW-1:0] src_ptr, dst_ptr, cyc_addr, addr_calc;
   logic [DW-1:0] src_val, dst_val, res, mdr;

   dos_decode #(.FAST_MOVE(FAST_MOVE)) u_dec (
      .instr(instr), .fld(fld_d), .exec_ok(exec_ok), .skip_dst(skip_d)
   );

   function automatic logic [AW-1:0] reg_addr(input logic [AW-1:0] base,
                                              input logic [DOS_RW-1:0] r);
      return base + AW'({r, 1'b0});
   endfunction

   function automatic dos_state_e after(input dos_state_e s, input dos_fields_t f,
                                        input logic skip);
      case (s)
         ST_SPTR: return ST_SRD;
         ST_SRD:  return (f.dmode == AM_IND) ? ST_DPTR : (skip ? ST_ALU : ST_DRD);
         ST_DPTR: return skip ? ST_ALU : ST_DRD;
         ST_DRD:  return ST_ALU;
         ST_ALU:  return ST_WR;
         default: return ST_IDLE;
      endcase
   endfunction

   always_comb begin
      case (state)
         ST_SPTR: addr_calc = reg_addr(wp, fld_q.sreg);
         ST_SRD:  addr_calc = (fld_q.smode == AM_IND) ? src_ptr : reg_addr(wp, fld_q.sreg);
         ST_DPTR: addr_calc = reg_addr(wp, fld_q.dreg);
         default: addr_calc = (fld_q.dmode == AM_IND) ? dst_ptr : reg_addr(wp, fld_q.dreg);
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state       <= ST_IDLE;
         ph          <= PH_ADDR;
         fld_q       <= '0;
         skip_q      <= 1'b0;
         src_ptr     <= '0;
         dst_ptr     <= '0;
         cyc_addr    <= '0;
         src_val     <= '0;
         dst_val     <= '0;
         res         <= '0;
         mdr         <= '0;
         mem_req     <= 1'b0;
         mem_we      <= 1'b0;
         mem_addr    <= '0;
         mem_wdata   <= '0;
         done        <= 1'b0;
         unsupported <= 1'b0;
      end else begin
         done        <= 1'b0;
         unsupported <= 1'b0;
         if (state == ST_IDLE) begin
            ph <= PH_ADDR;
            if (start) begin
               fld_q  <= fld_d;
               skip_q <= skip_d;
               if (exec_ok) state <= (fld_d.smode == AM_IND) ? ST_SPTR : ST_SRD;
               else         unsupported <= 1'b1;
            end
         end else begin
            case (ph)
               PH_ADDR: begin
                  cyc_addr <= addr_calc;
                  ph       <= PH_DRIVE;
               end
               PH_DRIVE: begin
                  mem_addr  <= cyc_addr;
                  mem_we    <= (state == ST_WR);
                  mem_wdata <= res;
                  mem_req   <= (state != ST_ALU);
                  ph        <= PH_STROBE;
               end
               PH_STROBE: begin
                  if (state == ST_ALU) begin
                     ph <= PH_CAPT;
                  end else if (mem_req && mem_ack) begin
                     mdr     <= mem_rdata;
                     mem_req <= 1'b0;
                     ph      <= PH_CAPT;
                  end
               end
               default: begin
                  case (state)
                     ST_SPTR: src_ptr <= mdr[AW-1:0];
                     ST_SRD:  src_val <= mdr;
                     ST_DPTR: dst_ptr <= mdr[AW-1:0];
                     ST_DRD:  dst_val <= mdr;
                     ST_ALU:  res     <= alu_res;
                     default: done    <= 1'b1;
                  endcase
                  state <= after(state, fld_q, skip_q);
                  ph    <= PH_ADDR;
               end
            endcase
         end
      end
   end

   assign busy     = (state != ST_IDLE);
   assign alu_op   = fld_q.op;
   assign alu_byte = fld_q.bsel;
   assign alu_src  = src_val;
   assign alu_dst  = dst_val;
endmodule

// File: rtl/dos_sequencer_chk.sv
module dos_sequencer_chk #(
   parameter int AW = 16
) (
   input logic          clk,
   input logic          rst_n,
   input logic          busy,
   input logic          done,
   input logic          unsupported,
   input logic          mem_req,
   input logic          mem_we,
   input logic          mem_ack,
   input logic [AW-1:0] mem_addr
);
   // R10
   req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req && !mem_ack |=> mem_req && $stable(mem_addr) && $stable(mem_we));

   // R10
   req_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(mem_req) |-> $past(mem_ack));

   // R11
   done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   // R11
   done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> !busy && !mem_req && !unsupported);

   // R1
   unsup_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      unsupported |-> !busy && !mem_req);

   // R9
   req_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req |-> busy);
endmodule

bind dos_sequencer dos_sequencer_chk #(.AW(AW)) u_chk (
   .clk(clk), .rst_n(rst_n), .busy(busy), .done(done),
   .unsupported(unsupported), .mem_req(mem_req), .mem_we(mem_we),
   .mem_ack(mem_ack), .mem_addr(mem_addr)
);

// File: tb/dos_sequencer_tb.sv
`timescale 1ns/1ps
module dos_sequencer_tb;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start = 1'b0;
   logic [15:0] instr = '0;
   logic [15:0] wp = '0;
   logic        busy, done, unsupported, mem_req, mem_we, mem_ack;
   logic [15:0] mem_addr, mem_wdata, mem_rdata, alu_src, alu_dst, alu_res;
   logic [2:0]  alu_op;
   logic        alu_byte;

   int checks = 0;
   int fails  = 0;
   int cyc    = 0;
   int mem_wait = 0;
   int wcnt = 0;

   logic [15:0] mem [256];
   logic [15:0] log_addr [16];
   logic        log_we   [16];
   int          log_n = 0;

   always #4 clk = ~clk;

   dos_sequencer #(.AW(16), .DW(16), .FAST_MOVE(1'b1)) u_dut (
      .clk(clk), .rst_n(rst_n), .start(start), .instr(instr), .wp(wp),
      .busy(busy), .done(done), .unsupported(unsupported),
      .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
      .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .mem_ack(mem_ack),
      .alu_op(alu_op), .alu_byte(alu_byte), .alu_src(alu_src),
      .alu_dst(alu_dst), .alu_res(alu_res)
   );

   function automatic logic [15:0] f16(input logic [2:0] op, input logic [15:0] a,
                                       input logic [15:0] b);
      case (op)
         3'b111:  return b | a;
         3'b110:  return a;
         3'b101:  return b + a;
         3'b011:  return b - a;
         3'b010:  return b & ~a;
         default: return b;
      endcase
   endfunction

   function automatic logic [15:0] alu_f(input logic [2:0] op, input logic bs,
                                         input logic [15:0] a, input logic [15:0] b);
      logic [15:0] hi;
      hi = f16(op, {a[15:8], 8'h00}, {b[15:8], 8'h00});
      return bs ? {hi[15:8], b[7:0]} : f16(op, a, b);
   endfunction

   assign alu_res = alu_f(alu_op, alu_byte, alu_src, alu_dst);

   function automatic int idx(input logic [15:0] a);
      return int'(a[8:1]);
   endfunction

   // memory model: registered acknowledge after mem_wait extra clocks
   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mem_ack   <= 1'b0;
         mem_rdata <= '0;
         wcnt      <= 0;
      end else if (mem_ack) begin
         mem_ack <= 1'b0;
      end else if (mem_req) begin
         if (wcnt >= mem_wait) begin
            mem_ack   <= 1'b1;
            wcnt      <= 0;
            mem_rdata <= mem[idx(mem_addr)];
            if (mem_we) mem[idx(mem_addr)] <= mem_wdata;
            if (log_n < 16) begin
               log_addr[log_n] = mem_addr;
               log_we[log_n]   = mem_we;
               log_n = log_n + 1;
            end
         end else begin
            wcnt <= wcnt + 1;
         end
      end
   end

   task automatic check(input logic ok, input string tag, input logic [31:0] act,
                        input logic [31:0] exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
      end
   endtask

   task automatic finish_run();
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   endtask

   always @(posedge clk) begin
      cyc++;
      if (cyc > 150000) begin
         checks++;
         fails++;
         $display("FAIL watchdog: actual %0d expected %0d", cyc, 150000);
         finish_run();
      end
   end

   task automatic run_one(input logic [15:0] ins, input logic [15:0] wpv, input int w);
      logic [15:0] ea [8];
      logic        ew [8];
      int          en;
      logic [15:0] sa, da, sv, dv, ed;
      logic [2:0]  op;
      logic        bs, ok, ind;
      int          lat, elat;
      string       tg;
      op  = ins[15:13];
      bs  = ins[12];
      ok  = (ins[15:14] != 2'b00) && !ins[11] && !ins[5];
      ind = ins[4] || ins[10];
      en  = 0;
      sv  = '0;
      dv  = '0;
      sa  = wpv + {11'd0, ins[3:0], 1'b0};
      if (ins[5:4] == 2'b01) begin ea[en] = sa; ew[en] = 0; en++; sa = mem[idx(sa)]; end
      sv = mem[idx(sa)]; ea[en] = sa; ew[en] = 0; en++;
      da = wpv + {11'd0, ins[9:6], 1'b0};
      if (ins[11:10] == 2'b01) begin ea[en] = da; ew[en] = 0; en++; da = mem[idx(da)]; end
      if (!(op == 3'b110 && !bs)) begin dv = mem[idx(da)]; ea[en] = da; ew[en] = 0; en++; end
      ea[en] = da; ew[en] = 1; en++;
      ed   = alu_f(op, bs, sv, dv);
      elat = 1 + (5 + w) * en + 4;

      @(negedge clk);
      instr = ins; wp = wpv; mem_wait = w; log_n = 0; start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      lat = 1;
      while (!done && !unsupported && lat < 400) begin
         @(negedge clk);
         lat++;
      end
      if (!ok) begin
         tg = (ins[15:14] == 2'b00) ? "R1" : "R2";
         check(unsupported === 1'b1 && lat == 1, tg, lat, 1);
         check(log_n == 0, tg, log_n, 0);
      end else begin
         check(done === 1'b1 && lat == elat, (w > 0) ? "R10" : "R9", lat, elat);
         check(log_n == en, (op == 3'b110) ? "R7" : "R6", log_n, en);
         for (int i = 0; i < en && i < log_n; i++)
            check(log_addr[i] == ea[i] && log_we[i] == ew[i], ind ? "R5" : "R4",
                  {log_we[i], log_addr[i]}, {ew[i], ea[i]});
         check(mem[idx(da)] == ed, "R8", mem[idx(da)], ed);
         check(alu_op == op && alu_byte == bs, "R3", {alu_op, alu_byte}, {op, bs});
      end
      @(negedge clk);
      check(!done && !busy, "R11", {done, busy}, 0);
   endtask

   function automatic logic [15:0] mk(input logic [2:0] op, input logic bs,
                                      input logic [1:0] dm, input logic [3:0] dr,
                                      input logic [1:0] sm, input logic [3:0] sr);
      return {op, bs, dm, dr, sm, sr};
   endfunction

   initial begin
      int unsigned seed;
      seed = $urandom(32'h1DEA);
      for (int i = 0; i < 256; i++) mem[i] = 16'($urandom);
      repeat (3) @(negedge clk);
      check(!busy && !done && !unsupported && !mem_req, "R11", {busy, done, unsupported, mem_req}, 0);
      rst_n = 1'b1;

      // directed corners
      run_one(mk(3'b101, 0, 2'b00, 4'd3, 2'b00, 4'd7), 16'h0040, 0); // add, 20 clocks
      run_one(mk(3'b110, 0, 2'b00, 4'd1, 2'b00, 4'd2), 16'h0040, 0); // word move, fast path
      run_one(mk(3'b110, 1, 2'b00, 4'd1, 2'b00, 4'd2), 16'h0040, 0); // byte move, full path
      run_one(mk(3'b011, 0, 2'b01, 4'd5, 2'b01, 4'd9), 16'h0080, 0); // both indirect
      run_one(mk(3'b111, 1, 2'b01, 4'd15, 2'b00, 4'd0), 16'h0100, 0);
      run_one(mk(3'b101, 0, 2'b00, 4'd4, 2'b00, 4'd4), 16'h0060, 3); // waits
      run_one(mk(3'b010, 0, 2'b00, 4'd2, 2'b10, 4'd1), 16'h0040, 0); // symbolic src
      run_one(mk(3'b100, 0, 2'b11, 4'd2, 2'b00, 4'd1), 16'h0040, 0); // autoinc dst
      run_one(16'h0000, 16'h0040, 0);
      run_one(16'h2C41, 16'h0040, 0);
      run_one(16'h1F05, 16'h0040, 0);
      run_one(16'h0A12, 16'h0040, 0);

      for (int n = 0; n < 80; n++) begin
         logic [15:0] ins;
         logic [1:0]  dm, sm;
         dm = ($urandom % 8 == 0) ? 2'(2 + $urandom % 2) : 2'($urandom % 2);
         sm = ($urandom % 8 == 0) ? 2'(2 + $urandom % 2) : 2'($urandom % 2);
         if ($urandom % 10 == 0) ins = 16'($urandom) & 16'h3FFF;
         else ins = mk(3'(2 + $urandom % 6), 1'($urandom), dm, 4'($urandom), sm, 4'($urandom));
         run_one(ins, 16'($urandom % 16'h01C0) & 16'hFFFE, int'($urandom % 3));
      end
      finish_run();
   end
endmodule